// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a single-channel voltage-output converter. A host writes 16-bit command words over three wires: an active-low select, a serial clock and a data line. The three pins are brought into a faster system clock through synchronizers. Serial clock falling edges are detected and counted there, and the word is assembled most significant bit first. When the sixteenth edge arrives, the word is latched and decoded. The upper four bits act as an opcode. One opcode loads a new converter code. Another opcode either wakes the output or parks it in one of three power-down terminations.

The output code register is double buffered. The shift register can collect the next word while the code presented to the converter stays constant until a load command completes. The code width is a parameter: 12, 10 or 8 bits. At 12 bits the whole payload is the code. At 10 and 8 bits the code sits directly above two dedicated selector bits.

The serial link has no back-pressure. The host paces it, and every completed word is acted on at once. The results leave the block as plain level registers together with a one-cycle update strobe, so no ready signal exists at either edge.

Top module: `dac_serial_if`

## Requirements
- R1: After reset, dac_code is 0, term_sel is 0, pd_active is 0 and upd_pulse is 0.
- R2: Data is sampled on each falling edge of sclk while cs_n is low, most significant bit first. The sixteenth such edge completes a word: bits 15:12 are the opcode and bits 11:0 are the payload.
- R3: Falling edges of sclk while cs_n is high do not shift data and cause no register change.
- R4: If cs_n rises before the sixteenth edge, the partial word is dropped. The next low period counts from its first edge again.
- R5: Once a word completes, further sclk edges in the same low period are ignored until cs_n goes high and then low again.
- R6: Opcode 4'b0000 loads the code register. At 12-bit width the code is payload bits 11:0. At 10 or 8 bits it is payload bits RES_BITS+1:2. term_sel is left unchanged.
- R7: Opcode 4'b1111 copies payload bits 1:0 into term_sel and leaves dac_code unchanged. The selector values are: 00 means driven (wake), 01 means floating, 10 means a 1 kOhm pull to ground, and 11 means a 100 kOhm pull to ground.
- R8: Any other opcode changes no output and raises no update strobe.
- R9: upd_pulse is high for exactly one cycle per accepted load or power command, in the same cycle the new values appear. pd_active is 1 exactly when term_sel is not 00.
- R10: A word whose sixteenth falling edge is seen in the same system cycle as the rise of cs_n is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than sclk |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| dac_code | output | RES_BITS | Code presented to the converter |
| term_sel | output | 2 | Output termination selector |
| pd_active | output | 1 | High while the output is powered down |
| upd_pulse | output | 1 | One-cycle strobe on every register write |

## Verification
Two events can land in one system cycle: the sixteenth falling sclk edge that completes a word, and the rise of cs_n that clears the bit counter. The bench provokes this by releasing cs_n at the same instant it drops sclk for the last bit. Both pins pass through identical synchronizers, so the two events reach the receiver together. The case is judged correct when exactly one update strobe appears and it carries the full word's code. Further cases check that a select released a few edges early drops the word, and that edges past the sixteenth are ignored.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
package dac_cmd_pkg;
  localparam int FRAME_BITS   = 16;
  localparam int OP_BITS      = 4;
  localparam int PAYLOAD_BITS = FRAME_BITS - OP_BITS;

  localparam logic [OP_BITS-1:0] OP_LOAD  = 4'b0000;
  localparam logic [OP_BITS-1:0] OP_POWER = 4'b1111;

  localparam logic [1:0] TERM_DRIVE = 2'b00;
  localparam logic [1:0] TERM_FLOAT = 2'b01;
  localparam logic [1:0] TERM_1K    = 2'b10;
  localparam logic [1:0] TERM_100K  = 2'b11;
endpackage

// File: rtl/dac_pin_sync.sv
`timescale 1ns/1ps
module dac_pin_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign pin_o = stg[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
`timescale 1ns/1ps
module dac_frame_rx
  import dac_cmd_pkg::*;
#(
  parameter int FB = FRAME_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          sdi_s,
  output logic          frame_vld,
  output logic [FB-1:0] frame_word
);
  localparam int              CNT_W = $clog2(FB);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FB - 1);

  logic             sclk_q;
  logic             cs_d;
  logic             done;
  logic [CNT_W-1:0] cnt;
  logic [FB-2:0]    shreg;
  logic             fall;
  logic             take;

  assign fall = sclk_q & ~sclk_s;
  assign take = fall & ~cs_d & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_d       <= 1'b1;
      done       <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      sclk_q    <= sclk_s;
      cs_d      <= cs_s;
      frame_vld <= 1'b0;
      if (take) begin
        if (cnt == LAST) begin
          frame_word <= {shreg, sdi_s};
          frame_vld  <= 1'b1;
          done       <= 1'b1;
          cnt        <= '0;
        end else begin
          shreg <= {shreg[FB-3:0], sdi_s};
          cnt   <= cnt + 1'b1;
        end
      end
      // select released: next low period starts a fresh word
      if (cs_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end
    end
  end

  assert_vld_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> ($past(fall) && !$past(cs_d)));
  assert_idle_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && cs_s) |=> !frame_vld);
  assert_one_word_per_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cs_s) |=> !frame_vld);
endmodule

// File: rtl/dac_cmd_regs.sv
`timescale 1ns/1ps
module dac_cmd_regs
  import dac_cmd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_vld,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic [RES_BITS-1:0]   dac_code,
  output logic [1:0]            term_sel,
  output logic                  pd_active,
  output logic                  upd_pulse
);
  logic [OP_BITS-1:0]      op;
  logic [PAYLOAD_BITS-1:0] payload;
  logic [1:0]              sel;
  logic [RES_BITS-1:0]     code_in;

  assign op      = frame_word[FRAME_BITS-1 -: OP_BITS];
  assign payload = frame_word[PAYLOAD_BITS-1:0];
  assign sel     = payload[1:0];

  generate
    if (RES_BITS == PAYLOAD_BITS) begin : g_full
      assign code_in = payload;
    end else if (RES_BITS == 10 || RES_BITS == 8) begin : g_packed
      assign code_in = payload[RES_BITS+1:2];
    end else begin : g_bad
      $error("dac_cmd_regs: RES_BITS must be 8, 10 or 12");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code  <= '0;
      term_sel  <= TERM_DRIVE;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= 1'b0;
      if (frame_vld) begin
        case (op)
          OP_LOAD: begin
            dac_code  <= code_in;
            upd_pulse <= 1'b1;
          end
          OP_POWER: begin
            term_sel  <= sel;
            upd_pulse <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign pd_active = (term_sel != TERM_DRIVE);

  assert_load_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && op == OP_LOAD) |=> (dac_code == $past(code_in)) && $stable(term_sel) && upd_pulse);
  assert_power_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && op == OP_POWER) |=> (term_sel == $past(sel)) && $stable(dac_code) && upd_pulse);
  assert_other_op_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && op != OP_LOAD && op != OP_POWER) |=> $stable(dac_code) && $stable(term_sel) && !upd_pulse);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);
  assert_no_write_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> !upd_pulse);
endmodule

// File: rtl/dac_serial_if.sv
`timescale 1ns/1ps
module dac_serial_if
  import dac_cmd_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdi,
  output logic [RES_BITS-1:0] dac_code,
  output logic [1:0]          term_sel,
  output logic                pd_active,
  output logic                upd_pulse
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0]      pins_s;
  logic                  frame_vld;
  logic [FRAME_BITS-1:0] frame_word;

  dac_pin_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin_i({cs_n, sclk, sdi}),
    .pin_o(pins_s)
  );

  dac_frame_rx #(
    .FB(FRAME_BITS)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .frame_vld (frame_vld),
    .frame_word(frame_word)
  );

  dac_cmd_regs #(
    .RES_BITS(RES_BITS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_vld (frame_vld),
    .frame_word(frame_word),
    .dac_code  (dac_code),
    .term_sel  (term_sel),
    .pd_active (pd_active),
    .upd_pulse (upd_pulse)
  );

  assert_pd_tracks_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && term_sel == TERM_DRIVE) |-> !pd_active);
endmodule

// File: tb/dac_serial_if_tb.sv
`timescale 1ns/1ps
module dac_serial_if_tb_top;
  localparam int RES = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [RES-1:0] dac_code;
  logic [1:0]     term_sel;
  logic           pd_active;
  logic           upd_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [RES+1:0] exp_q[$];
  logic [RES-1:0] cur_code = '0;
  logic [1:0]     cur_term = '0;
  logic           upd_prev = 1'b0;

  always #10 clk = ~clk;

  dac_serial_if #(.RES_BITS(RES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dac_code(dac_code), .term_sel(term_sel), .pd_active(pd_active), .upd_pulse(upd_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model of the command decode, fed from the requirements
  task automatic model_apply(input logic [15:0] w);
    if (w[15:12] == 4'b0000) begin
      cur_code = (RES == 12) ? w[11:0] : RES'(w[11:2]);
      exp_q.push_back({cur_term, cur_code});
    end else if (w[15:12] == 4'b1111) begin
      cur_term = w[1:0];
      exp_q.push_back({cur_term, cur_code});
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n, input bit apply, input bit coincide);
    if (apply && n >= 16) model_apply(bits[n-1 -: 16]);
    @(negedge clk);
    cs_n = 1'b0;
    ticks(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      ticks(1);
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
      if (coincide && i == 0) cs_n = 1'b1;
      ticks(3);
    end
    ticks(2);
    cs_n = 1'b1;
    ticks(4);
  endtask

  task automatic clocks_high(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      ticks(1);
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
      ticks(3);
    end
  endtask

  task automatic settle(input string req);
    ticks(30);
    chk(exp_q.size() == 0, req, "missing update strobe, pending", exp_q.size(), 0);
    exp_q.delete();
    chk(dac_code == cur_code, req, "dac_code level", dac_code, cur_code);
    chk(term_sel == cur_term, req, "term_sel level", term_sel, cur_term);
    chk(pd_active == (cur_term != 2'b00), "R9", "pd_active level", pd_active, cur_term != 2'b00);
  endtask

  // monitor: every strobe pops one expected item
  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_pulse && upd_prev) chk(1'b0, "R9", "strobe wider than one cycle", 2, 1);
      if (upd_pulse) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected update strobe", 1, 0);
        end else begin
          logic [RES+1:0] e;
          e = exp_q.pop_front();
          chk(dac_code == e[RES-1:0], "R6", "dac_code at strobe", dac_code, e[RES-1:0]);
          chk(term_sel == e[RES+1:RES], "R7", "term_sel at strobe", term_sel, e[RES+1:RES]);
          chk(pd_active == (e[RES+1:RES] != 2'b00), "R9", "pd_active at strobe",
              pd_active, e[RES+1:RES] != 2'b00);
        end
      end
      upd_prev <= upd_pulse;
    end
  end

  initial begin
    ticks(5);
    rst_n = 1'b1;
    ticks(5);
    chk(dac_code == '0, "R1", "reset dac_code", dac_code, 0);
    chk(term_sel == 2'b00, "R1", "reset term_sel", term_sel, 0);
    chk(!pd_active, "R1", "reset pd_active", pd_active, 0);
    chk(!upd_pulse, "R1", "reset upd_pulse", upd_pulse, 0);

    send(32'h0ABC, 16, 1, 0); settle("R2");
    send(32'h0000, 16, 1, 0); settle("R6");
    send(32'h0FFF, 16, 1, 0); settle("R6");
    send(32'hF001, 16, 1, 0); settle("R7");
    send(32'hF002, 16, 1, 0); settle("R7");
    send(32'hF003, 16, 1, 0); settle("R7");
    send(32'h0123, 16, 1, 0); settle("R6");
    send(32'hF000, 16, 1, 0); settle("R7");
    send(32'h5AAA, 16, 1, 0); settle("R8");
    send(32'h8555, 16, 1, 0); settle("R8");
    // partial word dropped, then a full one counts afresh
    send(32'h00AB, 8, 0, 0);  settle("R4");
    send(32'h0456, 16, 1, 0); settle("R4");
    // twenty edges in one low period: only the first sixteen count
    send({12'h0, 16'h0789, 4'hF}, 20, 1, 0); settle("R5");
    send(32'hF002, 16, 1, 0); settle("R5");
    // edges with select high
    clocks_high(16'h0321); settle("R3");
    // final edge and select release in the same instant
    send(32'h0654, 16, 1, 1); settle("R10");
    send(32'hF000, 16, 1, 1); settle("R10");

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule